// File: doc/BRIEF.md
# Interrupt entry sequencer

This block takes over the bus of a small 8-bit CPU when an interrupt is accepted. It then runs the fixed entry sequence up to the first fetch of the service routine. At each instruction boundary it looks at the pending request lines, at the enable mask and at the global interrupt flag in the status word. If a request qualifies, or if the instruction just decoded is a software break, it latches the program counter, the stack pointer and the status word. It then runs an eight-cycle sequence: two idle opcode slots, three stack pushes into page 1 and two reads from the vector table in high memory. In the last cycle it presents the new program counter, stack pointer and status word, together with a one-cycle done pulse.

The surrounding core drives `insn_boundary` once per instruction. It raises `brk_req` in the same cycle when that instruction is a break. While `busy` is high the core stalls, and it loads `new_pc`, `new_sp` and `new_psw` on `done`. The one-hot `irq_clr` pulse tells the request logic which pending flag to drop. Writes to the enable mask reach the acceptance logic one instruction late. A change to the global flag counts at the very next boundary.

Top module: `isq_entry_seq`

## Requirements
- R1: A hardware request is accepted only in a cycle with `insn_boundary`=1 while idle, `psw_in` bit 2 (global enable) = 1, and its pending bit and effective enable bit both set. A break (`brk_req`=1 at a boundary) is accepted whatever bit 2 is. With nothing accepted, `busy`, `mem_wr` and `mem_rd` stay 0.
- R2: Among several qualifying requests the lowest-numbered source is taken. A break takes precedence over any hardware request.
- R3: In cycles 3, 4 and 5 after the accepting edge the block writes three bytes. It writes PC[15:8] to 0x0100+SP, then PC[7:0] to 0x0100+SP-1, then the original status word to 0x0100+SP-2, with SP arithmetic modulo 256.
- R4: In cycles 6 and 7 the block reads the vector, low byte first and then the high byte. For source n the bytes are at 0xFFFE-2n and 0xFFFF-2n, and for a break they are at 0xFFE0 and 0xFFE1.
- R5: `busy` is high for exactly cycles 1 to 8 after acceptance. `done` is a single-cycle pulse in cycle 8, with `new_pc` = {high byte, low byte} as read.
- R6: `new_sp` equals the latched SP minus 3, modulo 256.
- R7: `new_psw` is the latched status word with bit 2 cleared. Bit 4 (break flag) is set for a break and left as it was for a hardware request.
- R8: In cycle 6 `irq_clr` is a one-hot pulse on the accepted source. It stays zero for a break and in every other cycle.
- R9: The enable mask used at a boundary is the `irq_en` value sampled at the previous boundary, so a mask change counts one instruction later.
- R10: `insn_boundary`, `brk_req` and changes of `sp_in`, `pc_in` or `psw_in` have no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_boundary | input | 1 | Current cycle is an instruction boundary |
| brk_req | input | 1 | Instruction at this boundary is a software break |
| irq_pend | input | N_SRC | Pending request flags |
| irq_en | input | N_SRC | Interrupt enable mask register |
| psw_in | input | 8 | Current status word |
| sp_in | input | 8 | Current stack pointer |
| pc_in | input | 16 | Return program counter |
| mem_rdata | input | 8 | Read data, valid in the cycle of `mem_rd` |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Bus write data |
| mem_wr | output | 1 | Bus write strobe |
| mem_rd | output | 1 | Bus read strobe |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | New PC, SP and PSW valid this cycle |
| irq_clr | output | N_SRC | One-hot clear of the accepted pending flag |
| new_pc | output | 16 | Service routine address |
| new_sp | output | 8 | Stack pointer after the pushes |
| new_psw | output | 8 | Status word after entry |

## Verification
A wrong state register shows up as a stack write or vector read in the wrong cycle or at the wrong address. The first affected bus cycle exposes it, at most five cycles after acceptance. A wrong latched source or break flag shows up in the vector address and `irq_clr` in cycle 6, and in `new_psw` at `done`. A stale or missing enable shadow shows up only at the following boundary, as an entry that starts or fails to start.

// File: rtl/isq_pkg.sv
package isq_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OP0,
        ST_OP1,
        ST_PCH,
        ST_PCL,
        ST_PSW,
        ST_VLO,
        ST_VHI,
        ST_LOAD
    } isq_state_e;

    localparam logic [7:0]  STACK_PAGE = 8'h01;
    localparam logic [15:0] VEC_TOP    = 16'hFFFE;
    localparam logic [15:0] VEC_BRK    = 16'hFFE0;
endpackage

// File: rtl/isq_prio.sv
module isq_prio #(
    parameter int N_SRC = 8,
    localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] req,
    output logic             hit,
    output logic [IW-1:0]    idx
);
    always_comb begin
        hit = |req;
        idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/isq_vecaddr.sv
module isq_vecaddr
    import isq_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [IW-1:0] idx,
    input  logic          brk,
    input  logic          hi,
    output logic [15:0]   addr
);
    logic [15:0] base;

    always_comb begin
        base = brk ? VEC_BRK : (VEC_TOP - 16'({idx, 1'b0}));
        addr = base + {15'd0, hi};
    end
endmodule

// File: rtl/isq_entry_seq.sv
module isq_entry_seq
    import isq_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int I_BIT = 2,
    parameter int B_BIT = 4,
    localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_boundary,
    input  logic             brk_req,
    input  logic [N_SRC-1:0] irq_pend,
    input  logic [N_SRC-1:0] irq_en,
    input  logic [7:0]       psw_in,
    input  logic [7:0]       sp_in,
    input  logic [15:0]      pc_in,
    input  logic [7:0]       mem_rdata,
    output logic [15:0]      mem_addr,
    output logic [7:0]       mem_wdata,
    output logic             mem_wr,
    output logic             mem_rd,
    output logic             busy,
    output logic             done,
    output logic [N_SRC-1:0] irq_clr,
    output logic [15:0]      new_pc,
    output logic [7:0]       new_sp,
    output logic [7:0]       new_psw
);
    typedef struct packed {
        isq_state_e       st;
        logic             brk;
        logic [IW-1:0]    src;
        logic [7:0]       sp;
        logic [15:0]      pc;
        logic [7:0]       psw;
        logic [7:0]       vlo;
        logic [7:0]       vhi;
        logic [N_SRC-1:0] ie;
    } seq_t;

    seq_t r_d, r_q;

    logic          hw_hit;
    logic [IW-1:0] hw_idx;
    logic [15:0]   vec_addr;
    logic          clr_en;

    isq_prio #(.N_SRC(N_SRC)) u_prio (
        .req (irq_pend & r_q.ie),
        .hit (hw_hit),
        .idx (hw_idx)
    );

    isq_vecaddr #(.N_SRC(N_SRC)) u_vec (
        .idx  (r_q.src),
        .brk  (r_q.brk),
        .hi   (r_q.st == ST_VHI),
        .addr (vec_addr)
    );

    // next-state
    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (insn_boundary) begin
                    r_d.ie = irq_en;
                    if (brk_req || (psw_in[I_BIT] && hw_hit)) begin
                        r_d.st  = ST_OP0;
                        r_d.brk = brk_req;
                        r_d.src = hw_idx;
                        r_d.sp  = sp_in;
                        r_d.pc  = pc_in;
                        r_d.psw = psw_in;
                    end
                end
            end
            ST_OP0: r_d.st = ST_OP1;
            ST_OP1: r_d.st = ST_PCH;
            ST_PCH: r_d.st = ST_PCL;
            ST_PCL: r_d.st = ST_PSW;
            ST_PSW: r_d.st = ST_VLO;
            ST_VLO: begin
                r_d.vlo = mem_rdata;
                r_d.st  = ST_VHI;
            end
            ST_VHI: begin
                r_d.vhi = mem_rdata;
                r_d.st  = ST_LOAD;
            end
            ST_LOAD: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // bus and result outputs
    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_wr    = 1'b0;
        mem_rd    = 1'b0;
        unique case (r_q.st)
            ST_PCH: begin
                mem_wr    = 1'b1;
                mem_addr  = {STACK_PAGE, r_q.sp};
                mem_wdata = r_q.pc[15:8];
            end
            ST_PCL: begin
                mem_wr    = 1'b1;
                mem_addr  = {STACK_PAGE, r_q.sp - 8'd1};
                mem_wdata = r_q.pc[7:0];
            end
            ST_PSW: begin
                mem_wr    = 1'b1;
                mem_addr  = {STACK_PAGE, r_q.sp - 8'd2};
                mem_wdata = r_q.psw;
            end
            ST_VLO, ST_VHI: begin
                mem_rd   = 1'b1;
                mem_addr = vec_addr;
            end
            default: ;
        endcase
    end

    assign busy   = (r_q.st != ST_IDLE);
    assign done   = (r_q.st == ST_LOAD);
    assign clr_en = (r_q.st == ST_VLO) && !r_q.brk;
    assign new_pc = {r_q.vhi, r_q.vlo};
    assign new_sp = r_q.sp - 8'd3;

    always_comb begin
        new_psw        = r_q.psw;
        new_psw[I_BIT] = 1'b0;
        if (r_q.brk) begin
            new_psw[B_BIT] = 1'b1;
        end
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_clr
        assign irq_clr[g] = clr_en && (r_q.src == IW'(g));
    end
endmodule

// File: rtl/isq_entry_chk.sv
module isq_entry_chk #(
    parameter int N_SRC = 8,
    parameter int I_BIT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [15:0]      mem_addr,
    input logic             mem_wr,
    input logic             mem_rd,
    input logic             busy,
    input logic             done,
    input logic [N_SRC-1:0] irq_clr,
    input logic [7:0]       new_psw
);
    // R3: pushes always land in page 1
    p_push_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr[15:8] == 8'h01));

    // R3: three consecutive writes, then a read
    p_push_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr) |=> mem_wr ##1 mem_wr ##1 (!mem_wr && mem_rd));

    // R4: vector reads stay inside the table
    p_vec_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr[15:5] == 11'h7FF));

    // R4: read and write never share a cycle
    p_bus_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R5: done is one cycle and ends the busy window
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R5: done follows the second vector read
    p_done_after_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd) |-> done);

    // R7: global enable is cleared in the result
    p_psw_i_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !new_psw[I_BIT]);

    // R8: clear is one-hot and only inside the sequence
    p_clr_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_clr) && (!(|irq_clr) || (busy && mem_rd)));

    // R1: bus is quiet while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_wr && !mem_rd && !done));
endmodule

bind isq_entry_seq isq_entry_chk #(.N_SRC(N_SRC), .I_BIT(I_BIT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_wr   (mem_wr),
    .mem_rd   (mem_rd),
    .busy     (busy),
    .done     (done),
    .irq_clr  (irq_clr),
    .new_psw  (new_psw)
);

// File: tb/tb_isq_entry_seq.sv
`timescale 1ns/1ps
module tb_isq_entry_seq;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          insn_boundary = 1'b0;
    logic          brk_req = 1'b0;
    logic [N-1:0]  irq_pend = '0;
    logic [N-1:0]  irq_en = '0;
    logic [7:0]    psw_in = '0;
    logic [7:0]    sp_in = '0;
    logic [15:0]   pc_in = '0;
    logic [7:0]    mem_rdata;
    logic [15:0]   mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_wr, mem_rd, busy, done;
    logic [N-1:0]  irq_clr;
    logic [15:0]   new_pc;
    logic [7:0]    new_sp, new_psw;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    assign mem_rdata = mem_addr[7:0] ^ 8'hA5;

    isq_entry_seq #(.N_SRC(N)) dut (
        .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary), .brk_req(brk_req),
        .irq_pend(irq_pend), .irq_en(irq_en), .psw_in(psw_in), .sp_in(sp_in),
        .pc_in(pc_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wr(mem_wr), .mem_rd(mem_rd), .busy(busy),
        .done(done), .irq_clr(irq_clr), .new_pc(new_pc), .new_sp(new_sp),
        .new_psw(new_psw)
    );

    // rows: enable mask, pending, psw, sp, pc, break, expected source (-1 none)
    localparam int NV = 8;
    localparam logic [7:0]  V_IE   [NV] = '{8'h01, 8'hFF, 8'h80, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h20};
    localparam logic [7:0]  V_PEND [NV] = '{8'h01, 8'h0C, 8'h80, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'h30};
    localparam logic [7:0]  V_PSW  [NV] = '{8'h04, 8'h06, 8'h84, 8'h04, 8'h00, 8'h00, 8'h04, 8'h14};
    localparam logic [7:0]  V_SP   [NV] = '{8'h80, 8'h40, 8'h01, 8'h20, 8'h20, 8'h10, 8'h00, 8'h77};
    localparam logic [15:0] V_PC   [NV] = '{16'h1234, 16'hABCD, 16'h0F0F, 16'h2222,
                                           16'h3333, 16'h5555, 16'h8001, 16'h0000};
    localparam bit          V_BRK  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam int          V_SRC  [NV] = '{0, 2, 7, -1, -1, 0, 0, 5};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_ie(input logic [7:0] ie);
        @(negedge clk);
        irq_en = ie; irq_pend = '0; brk_req = 1'b0; insn_boundary = 1'b1;
        @(negedge clk);
        insn_boundary = 1'b0;
    endtask

    task automatic fire(input logic [7:0] ie, input logic [7:0] pend, input logic [7:0] psw,
                        input logic [7:0] sp, input logic [15:0] pc, input bit brk);
        @(negedge clk);
        irq_en = ie; irq_pend = pend; psw_in = psw; sp_in = sp; pc_in = pc;
        brk_req = brk; insn_boundary = 1'b1;
        @(negedge clk);
        insn_boundary = 1'b0; brk_req = 1'b0;
    endtask

    task automatic expect_none(input string lbl);
        for (int k = 0; k < 3; k++) begin
            if (k > 0) @(negedge clk);
            chk($sformatf("R1 %s idle busy/bus", lbl), {busy, mem_wr, mem_rd}, 3'b000);
        end
        irq_pend = '0;
    endtask

    task automatic expect_entry(input string lbl, input int src, input bit brk,
                                input logic [7:0] sp, input logic [15:0] pc,
                                input logic [7:0] psw, input bit disturb);
        logic [15:0] lo_a, hi_a;
        logic [7:0]  epsw;
        logic [N-1:0] eclr;
        lo_a = brk ? 16'hFFE0 : 16'(16'hFFFE - 2 * src);
        hi_a = lo_a + 16'd1;
        epsw = (psw & 8'hFB) | (brk ? 8'h10 : 8'h00);
        eclr = brk ? '0 : N'(1) << src;
        for (int k = 0; k < 8; k++) begin
            if (k > 0) @(negedge clk);
            case (k)
                0: begin
                    chk($sformatf("R1 %s busy after accept", lbl), busy, 1'b1);
                    if (disturb) begin
                        insn_boundary = 1'b1; brk_req = 1'b1; sp_in = 8'h33;
                        pc_in = 16'hDEAD; psw_in = 8'hFF;
                    end
                end
                1: chk($sformatf("R5 %s no done early", lbl), {done, mem_wr}, 2'b00);
                2: chk($sformatf("R3 %s push pc high", lbl), {mem_wr, mem_addr, mem_wdata},
                       {1'b1, 8'h01, sp, pc[15:8]});
                3: chk($sformatf("R3 %s push pc low", lbl), {mem_wr, mem_addr, mem_wdata},
                       {1'b1, 8'h01, 8'(sp - 8'd1), pc[7:0]});
                4: chk($sformatf("R3 %s push psw", lbl), {mem_wr, mem_addr, mem_wdata},
                       {1'b1, 8'h01, 8'(sp - 8'd2), psw});
                5: begin
                    chk($sformatf("R4 %s vector low read", lbl), {mem_rd, mem_addr}, {1'b1, lo_a});
                    chk($sformatf("R8 %s clear pulse", lbl), irq_clr, eclr);
                    if (src >= 0 && !brk) chk($sformatf("R2 %s winner", lbl), irq_clr, eclr);
                end
                6: begin
                    chk($sformatf("R4 %s vector high read", lbl), {mem_rd, mem_addr}, {1'b1, hi_a});
                    chk($sformatf("R8 %s clear gone", lbl), irq_clr, '0);
                    if (disturb) begin insn_boundary = 1'b0; brk_req = 1'b0; end
                end
                7: begin
                    chk($sformatf("R5 %s done", lbl), {done, busy}, 2'b11);
                    chk($sformatf("R5 %s new pc", lbl), new_pc,
                        {hi_a[7:0] ^ 8'hA5, lo_a[7:0] ^ 8'hA5});
                    chk($sformatf("R6 %s new sp", lbl), new_sp, 8'(sp - 8'd3));
                    chk($sformatf("R7 %s new psw", lbl), new_psw, epsw);
                end
                default: ;
            endcase
        end
        @(negedge clk);
        chk($sformatf("R5 %s busy released", lbl), {busy, done}, 2'b00);
        if (disturb) chk($sformatf("R10 %s no restart", lbl), {busy, mem_wr, mem_rd}, 3'b000);
        irq_pend = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {busy, done, mem_wr, mem_rd, irq_clr}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 idle after reset", {busy, done}, 2'b00);

        for (int i = 0; i < NV; i++) begin
            load_ie(V_IE[i]);
            fire(V_IE[i], V_PEND[i], V_PSW[i], V_SP[i], V_PC[i], V_BRK[i]);
            if (V_BRK[i] || V_SRC[i] >= 0)
                expect_entry($sformatf("row%0d", i), V_SRC[i], V_BRK[i],
                             V_SP[i], V_PC[i], V_PSW[i], 1'b0);
            else
                expect_none($sformatf("row%0d", i));
        end

        // R9: mask written just before a boundary is not yet in force
        load_ie(8'h00);
        fire(8'h08, 8'h08, 8'h04, 8'h50, 16'h4321, 1'b0);
        expect_none("R9 mask late");
        fire(8'h08, 8'h08, 8'h04, 8'h50, 16'h4321, 1'b0);
        expect_entry("R9 mask active", 3, 1'b0, 8'h50, 16'h4321, 8'h04, 1'b0);

        // R1: pending without a boundary does nothing
        @(negedge clk);
        irq_en = 8'hFF; irq_pend = 8'hFF; psw_in = 8'h04;
        repeat (3) @(negedge clk);
        chk("R1 no boundary no accept", {busy, mem_wr}, 2'b00);
        irq_pend = '0;

        // R10: boundary, break and register changes during busy are ignored
        fire(8'h00, 8'h00, 8'h00, 8'h90, 16'hC0DE, 1'b1);
        expect_entry("R10 busy", 0, 1'b1, 8'h90, 16'hC0DE, 8'h00, 1'b1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule